// File: doc/BRIEF.md
# Abstract Register Command Sequencer

This block takes a register-access command from the debug bus and runs it against a halted processor core. A command names a core register, a transfer direction, a transfer width and two optional program-buffer runs. One run happens before the register transfer and one after it. The block holds a small bank of 32-bit data words that carry the transferred value. It drives a request/done handshake toward the core and reports its progress in a status word. That word has a busy flag and a sticky error code. The core, its instruction fetch from the program buffer and its register file sit outside the block. In the bench they are modelled by a stub.

The sequencer is a five-state machine.
- IDLE waits for a launch. A launch is a write to the command register, or an access to a data word whose re-run bit is set.
- IDLE → CHECK happens on a launch while the error code is zero.
- CHECK → IDLE happens when the width is not supported (error 2) or the core is not halted (error 4).
- CHECK → PRE when the before-run flag is set; otherwise CHECK → XFER.
- PRE → XFER on done.
- XFER → POST on done when the after-run flag is set; otherwise XFER → IDLE.
- POST → IDLE on done.
- In PRE, XFER or POST, a done that comes with an exception goes straight to IDLE with error 3.

The bus map is: address 0 is the status word, address 1 is the command, and addresses 4 to 7 are data words 0 to 3.

Top module: `abs_cmd_seq`

## Requirements
- R1: After reset the status word reads busy 0 and error 0. The program-buffer size (PROG_WORDS, default 8) appears in status bits 7:4, so the status reads 0x00000080. hart_req is low.
- R2: A write to the command register (address 1) while idle with error 0 makes status bit 3 (busy) read 1 from the next cycle. Busy stays 1 until the last phase of the command has ended.
- R3: Command bit 18 enables a program run (hart_op 1) before the transfer. Bit 17 enables a program run after it. Disabled phases are skipped. Each phase keeps hart_req high until one hart_done pulse.
- R4: With command bit 16 = 0, the transfer phase uses hart_op 2 and presents data word i on hart_wdata[32i+31:32i]. With bit 16 = 1, it uses hart_op 3, and on done the core's words are copied into data words 0 to n-1. Here n is the word count of the access width.
- R5: Width field bits 21:19 selects the access width: 2 means 32 bits (1 word), 3 means 64 bits (2 words) and 4 means 128 bits (4 words). Any other code, or a width larger than REG_BITS (default 64), sets error 2 and runs no phase.
- R6: A supported command issued while hart_halted is 0 sets error 4 and runs no phase.
- R7: hart_exc together with hart_done ends the command at once with error 3. Later phases are skipped, and no data word is changed.
- R8: A command write or a data-word access while busy sets error 1 if the error is zero. An ignored write changes neither the data word nor the running command.
- R9: The error code (status bits 2:0) is sticky. While it is nonzero, no command starts; a command write is only stored. A status write with any 1 in bits 2:0 clears it.
- R10: Status bit 8+N is the re-run bit for data word N. A read or write of data word N while idle with error 0 re-runs the stored command. A written value is in place before the transfer. Accesses to words whose bit is clear start nothing.
- R11: During the transfer phase, hart_regno carries command bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Debug bus write strobe |
| bus_rd | input | 1 | Debug bus read strobe |
| bus_addr | input | ADDR_W (3) | Debug bus word address |
| bus_wdata | input | 32 | Debug bus write data |
| bus_rdata | output | 32 | Debug bus read data (combinational) |
| hart_halted | input | 1 | Core is halted |
| hart_req | output | 1 | A phase is requested from the core |
| hart_op | output | 2 | Phase kind: 1 program run, 2 register write, 3 register read |
| hart_regno | output | 16 | Register number of the command |
| hart_wdata | output | NDATA*32 (128) | Data words toward the core |
| hart_done | input | 1 | One-cycle phase completion |
| hart_exc | input | 1 | Exception flag, valid with hart_done |
| hart_rdata | input | NDATA*32 (128) | Register value from the core, valid with hart_done |

## Verification
A vector table walks the command word through several combinations: no optional phase, before-run only, after-run only, both runs, both directions, and 32- and 64-bit widths. These cases are told apart by the order of phase kinds the core stub records and by which data words move. Other table rows pair a valid command with a not-halted core, pair unsupported widths with a halted core, and inject an exception in the first phase of each path. These rows separate the codes 2, 4 and 3 and show that a failed read leaves data word 0 alone. Directed sequences cover the following cases:
- a data write landing mid-command;
- a command written while an error is pending, then the clear;
- re-runs triggered by writing and by reading a data word, alongside an access to a word whose re-run bit is clear.

// File: rtl/acs_pkg.sv
`timescale 1ns/1ps
package acs_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_REGW = 2'd2,
        OP_REGR = 2'd3
    } hart_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PRE,
        ST_XFER,
        ST_POST
    } seq_state_e;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_BUSY  = 3'd1;
    localparam logic [2:0] ERR_UNSUP = 3'd2;
    localparam logic [2:0] ERR_EXC   = 3'd3;
    localparam logic [2:0] ERR_STATE = 3'd4;

    localparam int CMD_DIR_BIT  = 16;
    localparam int CMD_POST_BIT = 17;
    localparam int CMD_PRE_BIT  = 18;
    localparam int CMD_SIZE_LSB = 19;
endpackage

// File: rtl/acs_decode.sv
`timescale 1ns/1ps
module acs_decode import acs_pkg::*; #(
    parameter int REG_BITS = 64,
    parameter int NDATA    = 4
) (
    input  logic [21:0]      cmd,
    output logic [15:0]      regno,
    output logic             dir,
    output logic             pre,
    output logic             post,
    output logic             size_ok,
    output logic [NDATA-1:0] word_mask
);
    int nwords;

    always_comb begin
        regno = cmd[15:0];
        dir   = cmd[CMD_DIR_BIT];
        post  = cmd[CMD_POST_BIT];
        pre   = cmd[CMD_PRE_BIT];
        unique case (cmd[CMD_SIZE_LSB +: 3])
            3'd2:    nwords = 1;
            3'd3:    nwords = 2;
            3'd4:    nwords = 4;
            default: nwords = 0;
        endcase
        size_ok = (nwords != 0) && (nwords * 32 <= REG_BITS) && (nwords <= NDATA);
        for (int i = 0; i < NDATA; i++) begin
            word_mask[i] = (i < nwords);
        end
    end
endmodule

// File: rtl/acs_databank.sv
`timescale 1ns/1ps
module acs_databank #(
    parameter int NDATA = 4,
    localparam int DW   = NDATA * 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NDATA-1:0] bus_we,
    input  logic [31:0]      bus_wdata,
    input  logic             load_en,
    input  logic [NDATA-1:0] load_mask,
    input  logic [DW-1:0]    load_data,
    output logic [DW-1:0]    words
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words <= '0;
        end else begin
            for (int i = 0; i < NDATA; i++) begin
                if (load_en && load_mask[i]) begin
                    words[i*32 +: 32] <= load_data[i*32 +: 32];
                end else if (bus_we[i]) begin
                    words[i*32 +: 32] <= bus_wdata;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NDATA; g++) begin : g_chk
            assert_load_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (load_en && load_mask[g]) |=> (words[g*32 +: 32] == $past(load_data[g*32 +: 32])));
            assert_untouched_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!load_en && !bus_we[g]) |=> $stable(words[g*32 +: 32]));
        end
    endgenerate
endmodule

// File: rtl/acs_fsm.sv
`timescale 1ns/1ps
module acs_fsm import acs_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       busy_hit,
    input  logic       err_clr,
    input  logic       hart_halted,
    input  logic       size_ok,
    input  logic       pre,
    input  logic       post,
    input  logic       dir,
    input  logic       hart_done,
    input  logic       hart_exc,
    output logic       busy,
    output logic [2:0] err,
    output logic       hart_req,
    output logic [1:0] hart_op,
    output logic       load_en
);
    seq_state_e state_q, state_d;
    logic [2:0] err_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        err_set = ERR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (launch && err == ERR_NONE) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (!size_ok) begin
                    err_set = ERR_UNSUP;
                    state_d = ST_IDLE;
                end else if (!hart_halted) begin
                    err_set = ERR_STATE;
                    state_d = ST_IDLE;
                end else if (pre) begin
                    state_d = ST_PRE;
                end else begin
                    state_d = ST_XFER;
                end
            end
            ST_PRE: begin
                if (hart_done) begin
                    if (hart_exc) begin
                        err_set = ERR_EXC;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (hart_done) begin
                    if (hart_exc) begin
                        err_set = ERR_EXC;
                        state_d = ST_IDLE;
                    end else if (post) begin
                        state_d = ST_POST;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_POST: begin
                if (hart_done) begin
                    if (hart_exc) err_set = ERR_EXC;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b1;
        hart_req = 1'b0;
        hart_op  = OP_NONE;
        load_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_CHECK: ;
            ST_PRE, ST_POST: begin
                hart_req = 1'b1;
                hart_op  = OP_PROG;
            end
            ST_XFER: begin
                hart_req = 1'b1;
                hart_op  = dir ? OP_REGR : OP_REGW;
                load_en  = dir && hart_done && !hart_exc;
            end
            default: busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err <= ERR_NONE;
        end else if (err == ERR_NONE) begin
            if (err_set != ERR_NONE) err <= err_set;
            else if (busy_hit)       err <= ERR_BUSY;
        end else if (err_clr) begin
            err <= ERR_NONE;
        end
    end

    assert_exc_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hart_req && hart_done && hart_exc && !err_clr) |=> (!hart_req && err != ERR_NONE));
    assert_unsup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !size_ok && !err_clr) |=> (!busy && err != ERR_NONE));
    assert_not_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && size_ok && !hart_halted && !err_clr) |=> (!hart_req && err != ERR_NONE));
    assert_pre_then_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE && hart_done && !hart_exc) |=> (hart_op == OP_REGW || hart_op == OP_REGR));
    assert_xfer_then_post_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && hart_done && !hart_exc && post) |=> (hart_op == OP_PROG));
endmodule

// File: rtl/abs_cmd_seq.sv
`timescale 1ns/1ps
module abs_cmd_seq import acs_pkg::*; #(
    parameter int NDATA      = 4,
    parameter int REG_BITS   = 64,
    parameter int PROG_WORDS = 8,
    parameter int ADDR_W     = 3,
    localparam int DW        = NDATA * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              hart_halted,
    output logic              hart_req,
    output logic [1:0]        hart_op,
    output logic [15:0]       hart_regno,
    output logic [DW-1:0]     hart_wdata,
    input  logic              hart_done,
    input  logic              hart_exc,
    input  logic [DW-1:0]     hart_rdata
);
    localparam logic [ADDR_W-1:0] A_STAT = '0;
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
    localparam int                DATA_BASE = 1 << (ADDR_W - 1);
    localparam logic [3:0]        PSIZE = 4'(PROG_WORDS);

    logic [31:0]      cmd_q;
    logic [NDATA-1:0] auto_q, data_hit, data_we, word_mask;
    logic             cmd_wr, stat_wr, busy, launch, busy_hit, err_clr, load_en;
    logic             dir, pre, post, size_ok;
    logic [2:0]       err;
    logic [DW-1:0]    words;

    always_comb begin
        for (int n = 0; n < NDATA; n++) begin
            data_hit[n] = (bus_wr || bus_rd) && (int'(bus_addr) == DATA_BASE + n);
            data_we[n]  = bus_wr && data_hit[n] && !busy;
        end
        cmd_wr   = bus_wr && (bus_addr == A_CMD);
        stat_wr  = bus_wr && (bus_addr == A_STAT);
        busy_hit = busy && (cmd_wr || (|data_hit));
        launch   = !busy && (cmd_wr || (|(data_hit & auto_q)));
        err_clr  = stat_wr && (|bus_wdata[2:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            auto_q <= '0;
        end else begin
            if (cmd_wr && !busy) cmd_q <= bus_wdata;
            if (stat_wr)         auto_q <= bus_wdata[8 +: NDATA];
        end
    end

    acs_decode #(.REG_BITS(REG_BITS), .NDATA(NDATA)) i_decode (
        .cmd       (cmd_q[21:0]),
        .regno     (hart_regno),
        .dir       (dir),
        .pre       (pre),
        .post      (post),
        .size_ok   (size_ok),
        .word_mask (word_mask)
    );

    acs_databank #(.NDATA(NDATA)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (data_we),
        .bus_wdata (bus_wdata),
        .load_en   (load_en),
        .load_mask (word_mask),
        .load_data (hart_rdata),
        .words     (words)
    );

    acs_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .busy_hit    (busy_hit),
        .err_clr     (err_clr),
        .hart_halted (hart_halted),
        .size_ok     (size_ok),
        .pre         (pre),
        .post        (post),
        .dir         (dir),
        .hart_done   (hart_done),
        .hart_exc    (hart_exc),
        .busy        (busy),
        .err         (err),
        .hart_req    (hart_req),
        .hart_op     (hart_op),
        .load_en     (load_en)
    );

    assign hart_wdata = words;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT) begin
            bus_rdata[2:0]        = err;
            bus_rdata[3]          = busy;
            bus_rdata[7:4]        = PSIZE;
            bus_rdata[8 +: NDATA] = auto_q;
        end else if (bus_addr == A_CMD) begin
            bus_rdata = cmd_q;
        end else begin
            for (int n = 0; n < NDATA; n++) begin
                if (int'(bus_addr) == DATA_BASE + n) bus_rdata = words[n*32 +: 32];
            end
        end
    end

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && err == ERR_NONE) |=> busy);
    assert_busy_access_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cmd_wr || (|data_hit)) && !err_clr) |=> (err != ERR_NONE));
    assert_regno_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hart_req && $past(hart_req)) |-> $stable(hart_regno));
    assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err != ERR_NONE && !busy) |=> !busy);
endmodule

// File: tb/test_abs_cmd_seq.sv
`timescale 1ns/1ps
module test_abs_cmd_seq;
    localparam int NDATA = 4;
    localparam int DW    = NDATA * 32;
    localparam int LAT   = 3;

    typedef struct packed {
        logic [31:0] cmd;
        logic        halted;
        logic [1:0]  exc_at;
        logic [2:0]  err;
        logic [11:0] seq;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{32'h00101001, 1'b1, 2'd0, 3'd0, 12'h002},
        '{32'h001D0300, 1'b1, 2'd0, 3'd0, 12'h013},
        '{32'h00120005, 1'b1, 2'd0, 3'd0, 12'h021},
        '{32'h00170010, 1'b1, 2'd0, 3'd0, 12'h131},
        '{32'h00200001, 1'b1, 2'd0, 3'd2, 12'h000},
        '{32'h00080001, 1'b1, 2'd0, 3'd2, 12'h000},
        '{32'h00100007, 1'b0, 2'd0, 3'd4, 12'h000},
        '{32'h00160002, 1'b1, 2'd1, 3'd3, 12'h001},
        '{32'h00120003, 1'b1, 2'd1, 3'd3, 12'h002},
        '{32'h00180004, 1'b1, 2'd0, 3'd0, 12'h002},
        '{32'h00110009, 1'b1, 2'd1, 3'd3, 12'h003}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          hart_halted = 1'b1;
    logic          hart_req;
    logic [1:0]    hart_op;
    logic [15:0]   hart_regno;
    logic [DW-1:0] hart_wdata;
    logic          hart_done = 1'b0, hart_exc = 1'b0;
    logic [DW-1:0] hart_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    abs_cmd_seq i_abs_cmd_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hart_halted(hart_halted),
        .hart_req(hart_req), .hart_op(hart_op), .hart_regno(hart_regno),
        .hart_wdata(hart_wdata), .hart_done(hart_done), .hart_exc(hart_exc),
        .hart_rdata(hart_rdata)
    );

    // Core stub
    logic          tb_clr = 1'b1;
    logic          stub_active = 1'b0;
    int            stub_cnt = 0;
    int            ph_cnt = 0;
    int            exc_at = 0;
    logic [11:0]   seq = '0;
    logic [DW-1:0] cap_wdata = '0;
    logic [15:0]   cap_regno = '0;

    always @(posedge clk) begin
        if (tb_clr) begin
            seq         <= '0;
            ph_cnt      <= 0;
            stub_active <= 1'b0;
            hart_done   <= 1'b0;
            hart_exc    <= 1'b0;
        end else if (hart_done) begin
            hart_done <= 1'b0;
            hart_exc  <= 1'b0;
        end else if (hart_req && !stub_active) begin
            stub_active <= 1'b1;
            stub_cnt    <= LAT;
            seq         <= {seq[7:0], 2'b00, hart_op};
            ph_cnt      <= ph_cnt + 1;
            cap_regno   <= hart_regno;
            if (hart_op == 2'd2) cap_wdata <= hart_wdata;
        end else if (stub_active) begin
            if (stub_cnt <= 1) begin
                stub_active <= 1'b0;
                hart_done   <= 1'b1;
                hart_exc    <= (ph_cnt == exc_at);
                for (int i = 0; i < NDATA; i++) begin
                    hart_rdata[i*32 +: 32] <= {cap_regno, 16'hC000 + 16'(i)};
                end
            end else begin
                stub_cnt <= stub_cnt - 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 100; k++) begin
            bus_read(3'd0, s);
            if (!s[3]) break;
        end
    endtask

    task automatic stub_clear();
        @(negedge clk);
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
    endtask

    function automatic string tag_of(input logic [2:0] e);
        case (e)
            3'd2:    return "R5";
            3'd3:    return "R7";
            3'd4:    return "R6";
            default: return "R3";
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic [31:0] cmd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tb_clr = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(3'd0, s);
        check("R1 status", s, 32'h00000080);
        check("R1 hart_req", {31'd0, hart_req}, 32'd0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            cmd = VECS[i].cmd;
            bus_write(3'd0, 32'h7);
            bus_write(3'd4, 32'h5A5A0000 + i);
            bus_write(3'd5, 32'h6B6B0000 + i);
            hart_halted = VECS[i].halted;
            exc_at = int'(VECS[i].exc_at);
            stub_clear();
            bus_write(3'd1, cmd);
            wait_idle();
            bus_read(3'd0, s);
            check({tag_of(VECS[i].err), " err"}, {29'd0, s[2:0]}, {29'd0, VECS[i].err});
            check({tag_of(VECS[i].err), " phase order"}, {20'd0, seq}, {20'd0, VECS[i].seq});
            if (VECS[i].err == 3'd0) begin
                check("R11 regno", {16'd0, cap_regno}, {16'd0, cmd[15:0]});
                if (!cmd[16]) begin
                    check("R4 wdata word0", cap_wdata[31:0], 32'h5A5A0000 + i);
                    if (cmd[21:19] == 3'd3) check("R4 wdata word1", cap_wdata[63:32], 32'h6B6B0000 + i);
                end else begin
                    bus_read(3'd4, s);
                    check("R4 read word0", s, {cmd[15:0], 16'hC000});
                    if (cmd[21:19] == 3'd3) begin
                        bus_read(3'd5, s);
                        check("R4 read word1", s, {cmd[15:0], 16'hC001});
                    end else begin
                        bus_read(3'd5, s);
                        check("R4 word1 kept", s, 32'h6B6B0000 + i);
                    end
                end
            end else if (cmd[16]) begin
                bus_read(3'd4, s);
                check("R7 data kept", s, 32'h5A5A0000 + i);
            end
        end
        hart_halted = 1'b1;
        exc_at = 0;

        // R2 busy rise, R8 access while busy
        bus_write(3'd0, 32'h7);
        stub_clear();
        bus_write(3'd1, 32'h00150020);
        bus_read(3'd0, s);
        check("R2 busy", {31'd0, s[3]}, 32'd1);
        bus_write(3'd5, 32'hDEAD0000);
        wait_idle();
        bus_read(3'd0, s);
        check("R8 err busy", {29'd0, s[2:0]}, 32'd1);
        check("R8 run unaffected", {20'd0, seq}, 32'h013);
        bus_read(3'd5, s);
        check("R8 write ignored", s, 32'h6B6B000A);
        bus_read(3'd4, s);
        check("R8 read result", s, 32'h0020C000);

        // R9 sticky error blocks launch, then W1C
        stub_clear();
        bus_write(3'd1, 32'h00100042);
        repeat (8) @(negedge clk);
        bus_read(3'd0, s);
        check("R9 no busy", {31'd0, s[3]}, 32'd0);
        check("R9 err kept", {29'd0, s[2:0]}, 32'd1);
        check("R9 no phase", {20'd0, seq}, 32'd0);
        bus_write(3'd0, 32'h1);
        bus_read(3'd0, s);
        check("R9 err cleared", {29'd0, s[2:0]}, 32'd0);

        // R10 re-run on data access
        bus_write(3'd0, 32'h100);
        stub_clear();
        bus_write(3'd4, 32'h12345678);
        wait_idle();
        check("R10 rerun on write", {20'd0, seq}, 32'h002);
        check("R10 new data used", cap_wdata[31:0], 32'h12345678);
        stub_clear();
        bus_read(3'd5, s);
        repeat (8) @(negedge clk);
        check("R10 other word no run", {20'd0, seq}, 32'd0);
        bus_write(3'd1, 32'h00110042);
        wait_idle();
        stub_clear();
        bus_read(3'd4, s);
        wait_idle();
        check("R10 rerun on read", {20'd0, seq}, 32'h003);
        bus_read(3'd0, s);
        check("R10 status", s, 32'h00000180);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule